// File: doc/BRIEF.md
# Dual-Clock Cascadable Up/Down Counter

This block is a small counter that moves one step for each rising transition on one of two separate count inputs. One input counts up and the other counts down. Whichever input is not in use rests high. A parameter chooses between decimal counting, which wraps between 9 and 0, and plain binary counting, which wraps between 15 and 0. An active-high clear and an active-low parallel preset act on the visible count without waiting for a clock. Two active-low terminal flags, carry and borrow, let several stages be chained: a stage's carry drives the next stage's up input and its borrow drives the next stage's down input, with no gates between them.

A free-running system clock runs the block. Each count input passes through a flip-flop synchroniser, and the block looks for its low-to-high transition. A step is taken only when one input rises while the other is high. The count register updates on the third system-clock edge after a count input rises. Clear and preset take effect on the output at once and are stored on the next edge.

Top module: `updn_counter`

## Requirements
- R1: An active-low reset forces q to 0 at once, with no clock edge, and holds carry_n and borrow_n high. The counter stays at 0 after reset is released until a count edge arrives.
- R2: A rising transition on up_in while dn_in is high adds one to q. In binary mode (DECADE=0) the count goes from 15 to 0.
- R3: A rising transition on dn_in while up_in is high subtracts one from q. In binary mode the count goes from 0 to 15.
- R4: In decimal mode (DECADE=1), an up step from 9 gives 0. From an out-of-range value of 10 to 15, an up step gives 0 if the value is odd and the value plus one if it is even, so 10 goes to 11 and then to 0.
- R5: In decimal mode, a down step from 0 gives 9, and a down step from any other value, including 10 to 15, subtracts one.
- R6: While load_n is low, q equals data with no clock delay, and count edges have no effect. The last loaded value stays in q after load_n returns high.
- R7: While clr is high, q is 0 with no clock delay. Clear wins over load and counting, and q stays 0 after clr falls.
- R8: carry_n is low exactly while q is at its top value (9 in decimal mode, 15 in binary mode) and the synchronised up_in is low. The synchroniser makes it follow a fall of up_in after two system-clock edges.
- R9: borrow_n is low exactly while q is 0 and the synchronised dn_in is low, two system-clock edges after dn_in falls.
- R10: A rising transition on one count input while the other is low is ignored. Rising transitions on both inputs in the same clock cycle are also ignored.
- R11: After a count input rises, q keeps its old value through two system-clock edges and shows the new value after the third.
- R12: Two decimal stages chained carry-to-up and borrow-to-down count as one two-digit decimal counter in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| up_in | input | 1 | Up count input; a rising transition counts up; rests high |
| dn_in | input | 1 | Down count input; a rising transition counts down; rests high |
| load_n | input | 1 | Active-low preset enable |
| clr | input | 1 | Active-high clear |
| data | input | W | Preset value |
| q | output | W | Current count |
| carry_n | output | 1 | Active-low carry: top value while up_in is low |
| borrow_n | output | 1 | Active-low borrow: zero while dn_in is low |

## Verification
A count result is due on the third system-clock edge after its input rises. A terminal flag is due two edges after the active input falls. Clear and preset are due on q within the same cycle. The bench drives every input on a falling clock edge and holds each count level for six cycles before it samples. It makes this margin larger than any single latency so that a chained second stage, which adds five edges behind the first stage's input, has settled. The latency requirement is checked exactly, sampling after the second edge and after the third. Expected digits come from arithmetic models of both counting modes, built from the requirements.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stg_q <= 2'b00;
    else           stg_q <= stg_d;
  end

  assign rst_n_out = stg_q[1];
endmodule

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  always_comb sh_d = {sh_q[STAGES-2:0], din};

  // idle level of a count input is high: reset to 1 so no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/updn_step_arb.sv
module updn_step_arb
  import updn_pkg::*;
(
  input  logic  up_lvl,
  input  logic  up_rise,
  input  logic  dn_lvl,
  input  logic  dn_rise,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (up_rise && !dn_rise && dn_lvl)      step = STEP_UP;
    else if (dn_rise && !up_rise && up_lvl) step = STEP_DN;
  end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] data,
  input  step_e        step,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  generate
    if (DECADE) begin : g_dec
      always_comb begin
        if (cnt_q == TOP)                inc_v = '0;
        else if (cnt_q > TOP && cnt_q[0]) inc_v = '0;
        else                              inc_v = cnt_q + 1'b1;
        dec_v = (cnt_q == '0) ? TOP : cnt_q - 1'b1;
      end
    end else begin : g_bin
      always_comb begin
        inc_v = cnt_q + 1'b1;
        dec_v = cnt_q - 1'b1;
      end
    end
  endgenerate

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (clr)          cnt_d = '0;
    else if (!load_n) cnt_d = data;
    else begin
      case (step)
        STEP_UP: cnt_d = inc_v;
        STEP_DN: cnt_d = dec_v;
        default: cnt_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int W           = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_in,
  input  logic         dn_in,
  input  logic         load_n,
  input  logic         clr,
  input  logic [W-1:0] data,
  output logic [W-1:0] q,
  output logic         carry_n,
  output logic         borrow_n
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  logic         rst_sn;
  logic         up_lvl, up_rise, dn_lvl, dn_rise;
  step_e        step;
  logic [W-1:0] cnt_q;

  updn_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn)
  );

  updn_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst_n(rst_sn), .din(up_in), .lvl(up_lvl), .rise(up_rise)
  );

  updn_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst_n(rst_sn), .din(dn_in), .lvl(dn_lvl), .rise(dn_rise)
  );

  updn_step_arb u_arb (
    .up_lvl(up_lvl), .up_rise(up_rise),
    .dn_lvl(dn_lvl), .dn_rise(dn_rise),
    .step(step)
  );

  updn_count_core #(.W(W), .DECADE(DECADE)) u_core (
    .clk(clk), .rst_n(rst_sn), .clr(clr), .load_n(load_n),
    .data(data), .step(step), .cnt_q(cnt_q)
  );

  // clear and preset reach the output without a clock
  always_comb begin
    if (clr)          q = '0;
    else if (!load_n) q = data;
    else              q = cnt_q;
  end

  assign carry_n  = ~((q == TOP) && !up_lvl);
  assign borrow_n = ~((q == '0) && !dn_lvl);
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         up_in,
  input logic         dn_in,
  input logic         load_n,
  input logic         clr,
  input logic [W-1:0] data,
  input logic [W-1:0] q,
  input logic         carry_n,
  input logic         borrow_n
);
  // R7
  clear_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr) && load_n |-> q == '0);

  // R6
  preset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_n) && !clr |-> q == $past(data));

  // R8
  carry_needs_low_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> !$past(up_in, 2));

  // R9
  borrow_needs_low_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> !$past(dn_in, 2));

  // R11
  step_only_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && $past(load_n) && !clr && !$past(clr) && q != $past(q)) |->
      (($past(up_in, 3) && !$past(up_in, 4)) || ($past(dn_in, 3) && !$past(dn_in, 4))));

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!carry_n && !borrow_n));
endmodule

bind updn_counter updn_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_in(up_in), .dn_in(dn_in),
  .load_n(load_n), .clr(clr), .data(data), .q(q),
  .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/test_updn_counter.sv
module test_updn_counter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, up, dn, ld_n, clr;
  logic [3:0] data;
  logic [3:0] q_lo, q_bin, q_hi;
  logic       c_lo, b_lo, c_bin, b_bin, c_hi, b_hi;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  int e_lo, e_bin, e_hi;

  updn_counter #(.W(4), .DECADE(1'b1)) i_updn_counter (
    .clk(clk), .rst_n(rst_n), .up_in(up), .dn_in(dn), .load_n(ld_n), .clr(clr),
    .data(data), .q(q_lo), .carry_n(c_lo), .borrow_n(b_lo)
  );

  updn_counter #(.W(4), .DECADE(1'b0)) i_updn_counter_bin (
    .clk(clk), .rst_n(rst_n), .up_in(up), .dn_in(dn), .load_n(ld_n), .clr(clr),
    .data(data), .q(q_bin), .carry_n(c_bin), .borrow_n(b_bin)
  );

  updn_counter #(.W(4), .DECADE(1'b1)) i_updn_counter_hi (
    .clk(clk), .rst_n(rst_n), .up_in(c_lo), .dn_in(b_lo), .load_n(ld_n), .clr(clr),
    .data(data), .q(q_hi), .carry_n(c_hi), .borrow_n(b_hi)
  );

  function automatic int dinc(int v);
    if (v == 9) return 0;
    if (v > 9)  return (v % 2 == 1) ? 0 : v + 1;
    return v + 1;
  endfunction
  function automatic int ddec(int v);
    return (v == 0) ? 9 : v - 1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, int exp);
    total++;
    if (act !== 8'(exp)) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_all(string tag);
    chk({tag, " dec"}, {4'b0, q_lo}, e_lo);
    chk({tag, " bin"}, {4'b0, q_bin}, e_bin);
    chk("R12 upper digit", {4'b0, q_hi}, e_hi);
  endtask

  task automatic pulse_up(string tag);
    up = 1'b0;
    tick(6);
    chk("R8 carry dec", {7'b0, c_lo}, (e_lo == 9) ? 0 : 1);
    chk("R8 carry bin", {7'b0, c_bin}, (e_bin == 15) ? 0 : 1);
    chk("R9 borrow idle", {7'b0, b_lo}, 1);
    up = 1'b1;
    if (e_lo == 9) e_hi = dinc(e_hi);
    e_lo  = dinc(e_lo);
    e_bin = (e_bin + 1) % 16;
    tick(6);
    chk_all(tag);
  endtask

  task automatic pulse_dn(string tag);
    dn = 1'b0;
    tick(6);
    chk("R9 borrow dec", {7'b0, b_lo}, (e_lo == 0) ? 0 : 1);
    chk("R9 borrow bin", {7'b0, b_bin}, (e_bin == 0) ? 0 : 1);
    chk("R8 carry idle", {7'b0, c_lo}, 1);
    dn = 1'b1;
    if (e_lo == 0) e_hi = ddec(e_hi);
    e_lo  = ddec(e_lo);
    e_bin = (e_bin + 15) % 16;
    tick(6);
    chk_all(tag);
  endtask

  task automatic do_load(int v);
    ld_n = 1'b0;
    data = 4'(v);
    tick(1);
    chk("R6 preset", {4'b0, q_lo}, v);
    tick(2);
    ld_n = 1'b1;
    e_lo = v; e_bin = v; e_hi = v;
    tick(2);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; up = 1'b1; dn = 1'b1; ld_n = 1'b1; clr = 1'b0; data = 4'd0;
    e_lo = 0; e_bin = 0; e_hi = 0;
    tick(3);
    // R1 reset state
    chk("R1 reset q", {4'b0, q_lo}, 0);
    chk("R1 reset q bin", {4'b0, q_bin}, 0);
    chk("R1 reset carry", {7'b0, c_lo}, 1);
    chk("R1 reset borrow", {7'b0, b_lo}, 1);
    rst_n = 1'b1;
    tick(4);

    // R7 clear wins over load and counting
    do_load(6);
    clr = 1'b1;
    #1 chk("R7 clear immediate", {4'b0, q_lo}, 0);
    ld_n = 1'b0; data = 4'd5;
    #1 chk("R7 clear over load", {4'b0, q_bin}, 0);
    tick(1);
    ld_n = 1'b1;
    up = 1'b0; tick(6); up = 1'b1; tick(6);
    chk("R7 clear over count", {4'b0, q_lo}, 0);
    clr = 1'b0;
    tick(3);
    e_lo = 0; e_bin = 0; e_hi = 0;
    chk_all("R7 after clear");

    // R6 preset follows data, edges ignored
    ld_n = 1'b0; data = 4'd7;
    #1 chk("R6 follow 7", {4'b0, q_lo}, 7);
    data = 4'd3;
    #1 chk("R6 follow 3", {4'b0, q_lo}, 3);
    tick(1);
    up = 1'b0; tick(6); up = 1'b1; tick(6);
    chk("R6 edge ignored", {4'b0, q_lo}, 3);
    data = 4'd7;
    tick(1);
    ld_n = 1'b1;
    tick(3);
    e_lo = 7; e_bin = 7; e_hi = 7;
    chk_all("R6 held");

    // R4 / R2 decimal up from 7, R5 / R3 back down
    for (int i = 0; i < 5; i++) pulse_up("R4 up from 7");
    for (int i = 0; i < 5; i++) pulse_dn("R5 down to 7");

    // R2 / R3 binary wrap from 13
    do_load(13);
    for (int i = 0; i < 5; i++) pulse_up("R2 up from 13");
    for (int i = 0; i < 5; i++) pulse_dn("R3 down to 13");

    // R4 out-of-range values, R5 down from out-of-range
    do_load(10);
    pulse_up("R4 ten");
    pulse_up("R4 eleven");
    do_load(14);
    pulse_dn("R5 fourteen");

    // R11 latency
    do_load(3);
    up = 1'b0; tick(6);
    up = 1'b1;
    tick(2);
    chk("R11 not yet", {4'b0, q_lo}, 3);
    tick(1);
    chk("R11 due", {4'b0, q_lo}, 4);
    tick(3);
    e_lo = 4; e_bin = 4;

    // R10 edge while the other input is low, and both together
    do_load(5);
    dn = 1'b0; tick(6);
    up = 1'b0; tick(6);
    up = 1'b1; tick(6);
    chk("R10 other low", {4'b0, q_lo}, 5);
    dn = 1'b1; tick(6);
    e_lo = 4; e_bin = 4;
    chk_all("R3 after release");
    up = 1'b0; dn = 1'b0; tick(6);
    up = 1'b1; dn = 1'b1; tick(6);
    chk_all("R10 both edges");

    // sweep through the two-digit range
    clr = 1'b1; tick(2); clr = 1'b0; tick(2);
    e_lo = 0; e_bin = 0; e_hi = 0;
    for (int i = 0; i < 105; i++) pulse_up("R2 sweep");
    for (int i = 0; i < 110; i++) pulse_dn("R3 sweep");

    // R1 asynchronous reset in mid-run
    rst_n = 1'b0;
    #1 chk("R1 async dec", {4'b0, q_lo}, 0);
    chk("R1 async hi", {4'b0, q_hi}, 0);
    tick(2);
    rst_n = 1'b1;
    tick(4);
    e_lo = 0; e_bin = 0; e_hi = 0;
    chk_all("R1 after release");
    pulse_up("R1 count after reset");

    finish_run();
  end
endmodule